// File: doc/BRIEF.md
# Programmable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port placed behind a small processor register port. The processor uses four registers: a data register, a line-format register, a divisor register and a flag register. It reaches them with a select, a two-bit register address, read and write strobes and an eight-bit bidirectional data bus. A byte written to the data register waits in a one-word holding register until the transmit shifter is free. It then leaves on `txd` framed by a low start bit, optional parity and one or two high stop bits. On the receive side, `rxd` is oversampled at sixteen ticks per bit. Each completed character is moved into a one-word receive holding register, and the port raises ready or error flags for it.

The line format can be changed at run time. It covers the data length (5 to 8 bits, least significant bit first), parity on or off, even or odd parity, and one or two stop bits. A tick generator sets the oversampling rate: it pulses once every `divisor+1` clocks, so one bit lasts `16*(divisor+1)` clocks.

Both shifters are state machines.

The transmitter has the states TX_IDLE, TX_START, TX_DATA, TX_PAR and TX_STOP. Its transitions are:
- *load*: TX_IDLE to TX_START, on a tick while the holding register is full.
- *start done*: TX_START to TX_DATA.
- *data done*: TX_DATA to TX_PAR or to TX_STOP, after the last data bit.
- *parity done*: TX_PAR to TX_STOP.
- *reload*: TX_STOP to TX_START, when the last stop bit ends with the holding register full.
- *drain*: TX_STOP to TX_IDLE, when the last stop bit ends with the holding register empty.

The receiver has the states RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP. Its transitions are:
- *edge seen*: RX_IDLE to RX_START, on a tick that sees a low line.
- *false start*: RX_START to RX_IDLE, when the mid-bit sample is high.
- *start confirmed*: RX_START to RX_DATA, when the mid-bit sample is low.
- *data done*: RX_DATA to RX_PAR or to RX_STOP.
- *parity sampled*: RX_PAR to RX_STOP.
- *stop sampled*: RX_STOP to RX_IDLE.

Top module: `sio_core`

## Requirements
- R1: After reset, `txd` is 1, the flag register (address 3) reads 0x21, the format register (address 1) reads 0x03 and the divisor register (address 2) reads DEF_DIV. Whenever the transmitter is idle, `txd` is 1.
- R2: A transmitted character consists of the following bits, in order:
  - one start bit at 0;
  - the data bits, least significant first;
  - an optional parity bit;
  - one or two stop bits at 1.

  Each bit lasts exactly 16*(divisor+1) clocks, and `txd` changes only on a tick.
- R3: The parity bit makes the count of ones among the data and parity bits even when format bit 3 is 0, and odd when format bit 3 is 1.
- R4: A write to address 0 while the holding register is empty stores the byte. A write while it is full is dropped. The held byte moves to the shifter on the next tick when the transmitter is idle, or straight after the last stop bit, so that back-to-back characters leave no idle gap.
- R5: The format register has the following fields:
  - bits 1:0 set the data length, 5 plus the field value;
  - bit 2 enables parity;
  - bit 3 selects odd parity;
  - bit 4 selects two stop bits.
- R6: A received character is right-justified in the receive register (address 0 read), with the unused upper bits at 0. Flag bit 1 (ready) sets, and reading address 0 clears it.
- R7: A low pulse on `rxd` shorter than half a bit produces no character.
- R8: A parity mismatch on a received character sets flag bit 2.
- R9: A received character whose first stop bit samples 0 sets flag bit 3. The character is still delivered.
- R10: A character completing while ready is set sets flag bit 4 and replaces the stored byte.
- R11: Reading the flag register clears bits 2, 3 and 4. Bit 0 reads 1 when the holding register is empty, and bit 5 reads 1 when the transmitter is idle with nothing held.
- R12: `data_io` is not driven unless both `sel` and `rd` are high.
- R13: Address 2 holds the divisor, which is readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| sel | input | 1 | register port select |
| rd | input | 1 | read strobe |
| wr | input | 1 | write strobe |
| addr | input | 2 | register address |
| data_io | inout | 8 | bidirectional register data |
| txd | output | 1 | serial output |
| rxd | input | 1 | serial input |

## Verification
A transmit state machine in the wrong state, or a wrong bit or tick count, changes `txd` on the first clock where it departs from the expected waveform. The bench model compares the line on every clock, so such an error shows within one clock of going wrong. A receiver fault appears as a wrong byte or wrong flag bits, seen on the register read that follows the character's stop bit. Errors in the holding-register handshake show as a missing, repeated or extra character on the line, or as a wrong empty flag.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int BUS_W    = 8;
    localparam int OSR      = 16;
    localparam int CNT_W    = $clog2(OSR);
    localparam int IDX_W    = $clog2(BUS_W);
    localparam int LEN_W    = 2;
    localparam int MIN_BITS = 5;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_DIV  = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_t;

    typedef struct packed {
        logic             stop2;
        logic             odd;
        logic             par_en;
        logic [LEN_W-1:0] len;
    } line_cfg_t;

    localparam int CFG_W = $bits(line_cfg_t);

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_t;

    function automatic logic [BUS_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [BUS_W-1:0] m;
        m = '0;
        for (int i = 0; i < BUS_W; i++) begin
            if (i < MIN_BITS + int'(len)) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [IDX_W-1:0] last_idx(input logic [LEN_W-1:0] len);
        return IDX_W'(MIN_BITS - 1) + IDX_W'(len);
    endfunction
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == '0)   cnt_q <= div;
        else                    cnt_q <= cnt_q - 1'b1;
    end

    assign tick = (cnt_q == '0);
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  line_cfg_t     cfg,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    output logic          take,
    output logic          txd,
    output logic          busy
);
    localparam int IW = $clog2(DW);

    tx_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IW-1:0]    idx_q;
    logic [DW-1:0]    sh_q;
    logic             par_q;
    logic             bit_end, last_data, last_stop;

    assign bit_end   = tick && (cnt_q == CNT_W'(OSR - 1));
    assign last_data = (idx_q == IW'(last_idx(cfg.len)));
    assign last_stop = !cfg.stop2 || idx_q[0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    // next state and load handshake
    always_comb begin
        st_d = st_q;
        take = 1'b0;
        unique case (st_q)
            TX_IDLE:  if (tick && hold_full) begin
                          st_d = TX_START;
                          take = 1'b1;
                      end
            TX_START: if (bit_end) st_d = TX_DATA;
            TX_DATA:  if (bit_end && last_data) st_d = cfg.par_en ? TX_PAR : TX_STOP;
            TX_PAR:   if (bit_end) st_d = TX_STOP;
            TX_STOP:  if (bit_end && last_stop) begin
                          if (hold_full) begin
                              st_d = TX_START;
                              take = 1'b1;
                          end else begin
                              st_d = TX_IDLE;
                          end
                      end
            default:  st_d = TX_IDLE;
        endcase
    end

    // tick, bit index and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
            par_q <= 1'b0;
        end else if (take) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= hold_data;
            par_q <= (^(hold_data & DW'(len_mask(cfg.len)))) ^ cfg.odd;
        end else if (tick && st_q != TX_IDLE) begin
            cnt_q <= cnt_q + 1'b1;
            if (bit_end) begin
                if ((st_q == TX_DATA && !last_data) || st_q == TX_STOP)
                    idx_q <= idx_q + 1'b1;
                else
                    idx_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        busy = (st_q != TX_IDLE);
        unique case (st_q)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[idx_q];
            TX_PAR:   txd = par_q;
            TX_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  line_cfg_t     cfg,
    input  logic          rxd,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          perr,
    output logic          ferr
);
    localparam int IW = $clog2(DW);

    rx_state_t        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IW-1:0]    idx_q;
    logic [DW-1:0]    sh_q;
    logic             pacc_q, perr_pend;
    logic             mid, bit_end, last_data;

    assign mid       = tick && (cnt_q == CNT_W'(OSR / 2 - 1));
    assign bit_end   = tick && (cnt_q == CNT_W'(OSR - 1));
    assign last_data = (idx_q == IW'(last_idx(cfg.len)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE:  if (tick && !rxd) st_d = RX_START;
            RX_START: if (mid) st_d = rxd ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && last_data) st_d = cfg.par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (bit_end) st_d = RX_STOP;
            RX_STOP:  if (bit_end) st_d = RX_IDLE;
            default:  st_d = RX_IDLE;
        endcase
    end

    // sampling datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            sh_q      <= '0;
            pacc_q    <= 1'b0;
            perr_pend <= 1'b0;
        end else begin
            if (tick) begin
                if (st_q == RX_IDLE || (st_q == RX_START && mid)) cnt_q <= '0;
                else                                              cnt_q <= cnt_q + 1'b1;
            end
            if (st_q == RX_START && mid) begin
                idx_q     <= '0;
                sh_q      <= '0;
                pacc_q    <= 1'b0;
                perr_pend <= 1'b0;
            end
            if (st_q == RX_DATA && bit_end) begin
                sh_q[idx_q] <= rxd;
                pacc_q      <= pacc_q ^ rxd;
                idx_q       <= last_data ? '0 : idx_q + 1'b1;
            end
            if (st_q == RX_PAR && bit_end)
                perr_pend <= (pacc_q ^ rxd) != cfg.odd;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            data <= '0;
            perr <= 1'b0;
            ferr <= 1'b0;
        end else begin
            done <= (st_q == RX_STOP) && bit_end;
            if (st_q == RX_STOP && bit_end) begin
                data <= sh_q;
                perr <= perr_pend && cfg.par_en;
                ferr <= !rxd;
            end
        end
    end
endmodule

// File: rtl/sio_core.sv
module sio_core
    import sio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             rd,
    input  logic             wr,
    input  logic [1:0]       addr,
    inout  wire  [BUS_W-1:0] data_io,
    output logic             txd,
    input  logic             rxd
);
    localparam line_cfg_t CFG_RST = '{stop2: 1'b0, odd: 1'b0, par_en: 1'b0, len: 2'd3};

    reg_sel_t         rsel;
    logic             acc_rd, acc_wr, rd_data, rd_stat;
    line_cfg_t        cfg_q;
    logic [DIV_W-1:0] div_q;
    logic [BUS_W-1:0] thr_q, rhr_q, rd_mux;
    logic             thr_full, rx_rdy, perr_q, ferr_q, ovr_q;
    logic             rx_m1, rx_m2;
    logic             tick, take, tx_busy;
    logic             rx_done, rx_perr, rx_ferr;
    logic [BUS_W-1:0] rx_data;

    assign rsel    = reg_sel_t'(addr);
    assign acc_rd  = sel && rd;
    assign acc_wr  = sel && wr;
    assign rd_data = acc_rd && (rsel == REG_DATA);
    assign rd_stat = acc_rd && (rsel == REG_STAT);

    sio_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (div_q),
        .tick  (tick)
    );

    sio_tx #(.DW(BUS_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cfg       (cfg_q),
        .hold_full (thr_full),
        .hold_data (thr_q),
        .take      (take),
        .txd       (txd),
        .busy      (tx_busy)
    );

    sio_rx #(.DW(BUS_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cfg   (cfg_q),
        .rxd   (rx_m2),
        .done  (rx_done),
        .data  (rx_data),
        .perr  (rx_perr),
        .ferr  (rx_ferr)
    );

    // input synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_m1 <= 1'b1;
            rx_m2 <= 1'b1;
        end else begin
            rx_m1 <= rxd;
            rx_m2 <= rx_m1;
        end
    end

    // register writes and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= CFG_RST;
            div_q    <= DIV_W'(DEF_DIV);
            thr_q    <= '0;
            thr_full <= 1'b0;
            rhr_q    <= '0;
            rx_rdy   <= 1'b0;
            perr_q   <= 1'b0;
            ferr_q   <= 1'b0;
            ovr_q    <= 1'b0;
        end else begin
            if (acc_wr) begin
                unique case (rsel)
                    REG_DATA: if (!thr_full) thr_q <= data_io;
                    REG_CTRL: cfg_q <= line_cfg_t'(data_io[CFG_W-1:0]);
                    REG_DIV:  div_q <= data_io[DIV_W-1:0];
                    REG_STAT: ;
                    default:  ;
                endcase
            end
            if (take)                              thr_full <= 1'b0;
            else if (acc_wr && rsel == REG_DATA)   thr_full <= 1'b1;

            if (rx_done) begin
                rhr_q  <= rx_data;
                rx_rdy <= 1'b1;
            end else if (rd_data) begin
                rx_rdy <= 1'b0;
            end
            perr_q <= (perr_q && !rd_stat) || (rx_done && rx_perr);
            ferr_q <= (ferr_q && !rd_stat) || (rx_done && rx_ferr);
            ovr_q  <= (ovr_q  && !rd_stat) || (rx_done && rx_rdy && !rd_data);
        end
    end

    // read mux
    always_comb begin
        unique case (rsel)
            REG_DATA: rd_mux = rhr_q;
            REG_CTRL: rd_mux = BUS_W'(cfg_q);
            REG_DIV:  rd_mux = BUS_W'(div_q);
            REG_STAT: rd_mux = {{(BUS_W-6){1'b0}}, !tx_busy && !thr_full, ovr_q,
                                ferr_q, perr_q, rx_rdy, !thr_full};
            default:  rd_mux = '0;
        endcase
    end

    assign data_io = acc_rd ? rd_mux : {BUS_W{1'bz}};
endmodule

// File: rtl/sio_core_chk.sv
module sio_core_chk
    import sio_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic             rd,
    input logic             wr,
    input logic [1:0]       addr,
    input logic             txd,
    input logic             tx_busy,
    input logic             tick,
    input logic             thr_full,
    input logic [BUS_W-1:0] thr_q,
    input logic             rx_done,
    input logic             rx_rdy,
    input logic             perr_q,
    input logic             ferr_q,
    input logic             ovr_q
);
    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R2
    line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd));

    // R4
    full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr == REG_DATA && thr_full) |=> $stable(thr_q));

    // R6
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && addr == REG_DATA && !rx_done) |=> !rx_rdy);

    // R10
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_rdy && !(sel && rd && addr == REG_DATA)) |=> ovr_q);

    // R11
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && addr == REG_STAT && !rx_done) |=> !(perr_q || ferr_q || ovr_q));
endmodule

bind sio_core sio_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .rd       (rd),
    .wr       (wr),
    .addr     (addr),
    .txd      (txd),
    .tx_busy  (tx_busy),
    .tick     (tick),
    .thr_full (thr_full),
    .thr_q    (thr_q),
    .rx_done  (rx_done),
    .rx_rdy   (rx_rdy),
    .perr_q   (perr_q),
    .ferr_q   (ferr_q),
    .ovr_q    (ovr_q)
);

// File: tb/sio_core_tb.sv
module sio_core_tb;
    localparam int CLK_P   = 10;
    localparam int DEF_DIV = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       drv_en = 1'b0;
    logic [7:0] drv = 8'h00;
    wire  [7:0] data_w;
    logic       txd;
    logic       rxd = 1'b1;

    int n_chk = 0;
    int n_err = 0;
    int bit_clks = 16 * (DEF_DIV + 1);

    logic [11:0] exp_bits[$];
    int          exp_len[$];

    assign data_w = drv_en ? drv : 8'hzz;
    for (genvar i = 0; i < 8; i++) begin : g_pu
        pullup (data_w[i]);
    end

    always #(CLK_P/2) clk = ~clk;

    sio_core #(.DIV_W(8), .DEF_DIV(DEF_DIV)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .rd      (rd),
        .wr      (wr),
        .addr    (addr),
        .data_io (data_w),
        .txd     (txd),
        .rxd     (rxd)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = a;
        #1 v = data_w;
        @(negedge clk);
        sel = 1'b0; rd = 1'b0;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; drv = v; drv_en = 1'b1;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; drv_en = 1'b0;
    endtask

    // expected transmit frame: start, data LSB first, parity, stops
    task automatic push_frame(input logic [7:0] d, input int nb, input bit pe,
                              input bit odd, input int ns);
        logic [11:0] b;
        int n;
        logic p;
        b = '1;
        b[0] = 1'b0;
        p = odd;
        for (int i = 0; i < nb; i++) begin
            b[1 + i] = d[i];
            p ^= d[i];
        end
        n = 1 + nb;
        if (pe) begin
            b[n] = p;
            n++;
        end
        n += ns;
        exp_bits.push_back(b);
        exp_len.push_back(n);
    endtask

    // reference model of the line, compared on every clock
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd !== 1'b1) begin
                if (exp_bits.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL R4 actual=unexpected start expected=idle line");
                end else begin
                    logic [11:0] b;
                    int n, bad, tot;
                    logic got, want;
                    b = exp_bits.pop_front();
                    n = exp_len.pop_front();
                    bad = 0;
                    got = 1'b0;
                    want = 1'b0;
                    tot = n * bit_clks;
                    for (int c = 0; c < tot; c++) begin
                        if (c > 0) @(negedge clk);
                        if (txd !== b[c / bit_clks] && bad == 0) begin
                            bad = 1;
                            got = txd;
                            want = b[c / bit_clks];
                        end
                    end
                    n_chk++;
                    if (bad != 0) begin
                        n_err++;
                        $display("FAIL R2/R3 actual=%b expected=%b frame=%h", got, want, b);
                    end
                end
            end
        end
    end

    task automatic wait_tx_idle;
        logic [7:0] s;
        s = 8'h00;
        while ((s & 8'h21) != 8'h21) bus_rd(2'd3, s);
        repeat (4) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] d, input int nb, input bit pe, input bit odd,
                           input int ns, input bit bad_par, input bit bad_stop);
        logic p;
        p = odd ^ bad_par;
        @(negedge clk);
        rxd = 1'b0;
        repeat (bit_clks) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            p ^= d[i];
            repeat (bit_clks) @(negedge clk);
        end
        if (pe) begin
            rxd = p;
            repeat (bit_clks) @(negedge clk);
        end
        if (bad_stop) begin
            rxd = 1'b0;
            repeat (bit_clks * 3 / 4) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (bit_clks * (ns + 1)) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 txd idle", {7'd0, txd}, 8'h01);
        bus_rd(2'd3, v); chk("R1 status", v, 8'h21);
        bus_rd(2'd1, v); chk("R1 format", v, 8'h03);
        bus_rd(2'd2, v); chk("R1 divisor", v, 8'(DEF_DIV));

        // R13 divisor register
        bus_wr(2'd2, 8'h01);
        bit_clks = 32;
        bus_rd(2'd2, v); chk("R13 divisor", v, 8'h01);
        repeat (8) @(negedge clk);

        // R2 8 bits, no parity, one stop
        push_frame(8'hA5, 8, 0, 0, 1);
        bus_wr(2'd0, 8'hA5);
        wait_tx_idle();

        // R3 R5 7 bits, even parity
        bus_wr(2'd1, 8'h06);
        bus_rd(2'd1, v); chk("R5 format", v, 8'h06);
        push_frame(8'h53, 7, 1, 0, 1);
        bus_wr(2'd0, 8'h53);
        wait_tx_idle();

        // R3 R5 5 bits, odd parity, two stops
        bus_wr(2'd1, 8'h1C);
        push_frame(8'h1F, 5, 1, 1, 2);
        bus_wr(2'd0, 8'hFF);
        wait_tx_idle();

        // R4 back-to-back, third write dropped
        bus_wr(2'd1, 8'h03);
        push_frame(8'h11, 8, 0, 0, 1);
        push_frame(8'h22, 8, 0, 0, 1);
        bus_wr(2'd0, 8'h11);
        v = 8'h00;
        while (v[0] != 1'b1) bus_rd(2'd3, v);
        bus_wr(2'd0, 8'h22);
        bus_rd(2'd3, v); chk("R4 held full", v & 8'h21, 8'h00);
        bus_wr(2'd0, 8'h33);
        wait_tx_idle();
        repeat (2 * 32) @(negedge clk);
        chk("R4 queue drained", 8'(exp_bits.size()), 8'h00);

        // R6 receive 8N1
        send_rx(8'h3C, 8, 0, 0, 1, 0, 0);
        bus_rd(2'd3, v); chk("R6 ready", v, 8'h23);
        bus_rd(2'd0, v); chk("R6 data", v, 8'h3C);
        bus_rd(2'd3, v); chk("R6 ready cleared", v, 8'h21);

        // R6 six-bit character right-justified
        bus_wr(2'd1, 8'h01);
        send_rx(8'hED, 6, 0, 0, 1, 0, 0);
        bus_rd(2'd0, v); chk("R6 six-bit data", v, 8'h2D);

        // R7 short glitch
        @(negedge clk); rxd = 1'b0;
        repeat (3) @(negedge clk); rxd = 1'b1;
        repeat (64) @(negedge clk);
        bus_rd(2'd3, v); chk("R7 glitch ignored", v, 8'h21);

        // R8 good then bad even parity
        bus_wr(2'd1, 8'h06);
        send_rx(8'h5A, 7, 1, 0, 1, 0, 0);
        bus_rd(2'd3, v); chk("R8 good parity", v, 8'h23);
        bus_rd(2'd0, v); chk("R8 good data", v, 8'h5A);
        send_rx(8'h5A, 7, 1, 0, 1, 1, 0);
        bus_rd(2'd3, v); chk("R8 parity error", v, 8'h27);
        bus_rd(2'd3, v); chk("R11 error cleared", v, 8'h23);
        bus_rd(2'd0, v); chk("R8 data", v, 8'h5A);

        // R9 framing error
        bus_wr(2'd1, 8'h03);
        send_rx(8'h81, 8, 0, 0, 1, 0, 1);
        bus_rd(2'd3, v); chk("R9 framing error", v, 8'h2B);
        bus_rd(2'd3, v); chk("R11 framing cleared", v, 8'h23);
        bus_rd(2'd0, v); chk("R9 data", v, 8'h81);

        // R10 overrun
        send_rx(8'h12, 8, 0, 0, 1, 0, 0);
        send_rx(8'h34, 8, 0, 0, 1, 0, 0);
        bus_rd(2'd3, v); chk("R10 overrun", v, 8'h33);
        bus_rd(2'd0, v); chk("R10 newest data", v, 8'h34);
        bus_rd(2'd3, v); chk("R11 overrun cleared", v, 8'h21);

        // R12 bus released (pulled up) when not reading
        @(negedge clk);
        sel = 1'b0; rd = 1'b1; addr = 2'd3;
        #1 chk("R12 no select", data_w, 8'hFF);
        @(negedge clk);
        sel = 1'b1; rd = 1'b0; addr = 2'd1;
        #1 chk("R12 no read", data_w, 8'hFF);
        @(negedge clk);
        sel = 1'b0;

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule